// File: doc/BRIEF.md
# Serial Register Access Port (SPI Slave)

This block is a four-wire serial slave. An external controller uses it to read and write a bank of 64 eight-bit configuration and status registers. The controller pulls the active-low select line low and clocks in a command frame most significant bit first, in clock mode 0. The frame carries an 8-bit opcode, an 8-bit register address and a single delimiter bit whose value does not matter. A write frame then carries one data byte from the controller. A read frame instead returns the contents of the addressed register on the serial output, one bit per clock. Two further opcodes set and clear a write-enable latch, and that latch guards every register write.

The block itself stores no register contents. It presents a parallel register-file port: an address, a write data byte, a one-cycle write strobe and a combinational read data byte. The register bank sits behind that port. All serial inputs are brought into the system clock domain through synchronizers, and the serial clock edges are found there. The serial clock must therefore run well below the system clock.

Each select assertion carries exactly one command. Once a command has completed, further clocks are ignored until the select line goes high and low again. If select is released before a command completes, the command is dropped and nothing changes.

Top module: `spi_rf_slave`

## Requirements
- R1: After synchronous reset, `so` is low, `reg_we` is low and the write-enable latch is clear, so a write sent before any enable opcode does not reach the register file.
- R2: While select is low, input bits are sampled on rising serial clock edges, most significant bit first. The frame is opcode bits 0-7, address bits 8-15 and one delimiter bit at position 16. The delimiter value (0 or 1) has no effect.
- R3: A write (opcode 0x02) with the latch set and an address below 64 gives exactly one single-cycle `reg_we` pulse after the 8th data bit. During that pulse, `reg_addr` equals the address and `reg_wdata` equals the data byte.
- R4: A write with the write-enable latch clear produces no `reg_we` pulse and leaves every register unchanged.
- R5: Opcode 0x06 sets the latch and opcode 0x04 clears it. Each takes effect when its delimiter bit is received, and a later write is accepted or ignored to match.
- R6: A read (opcode 0x03) drives the addressed register on `so`, most significant bit first. The first bit is valid before the first rising edge after the delimiter. Each later bit changes after a falling edge.
- R7: `so` is low whenever select is high, and low during every bit of a frame outside the 8 read data bits.
- R8: Only one command is run per select assertion. Clocks and bits after the command completes, including a whole second command, have no effect.
- R9: Any opcode other than 0x02, 0x03, 0x04 and 0x06 is ignored. It causes no write, no latch change and no output on `so`.
- R10: Raising select before a command completes aborts it. No register and no latch state changes, and the next frame is decoded from its first bit.
- R11: An address of 64 or above makes a write do nothing and a read return 0x00. It never reaches a register through the low address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller (mode 0) |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data from the controller |
| so | output | 1 | Serial read data, held low when idle |
| reg_addr | output | 6 | Register-file address |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | One-cycle register-file write strobe |
| reg_rdata | input | 8 | Register-file read data for `reg_addr` |

## Verification
The bench writes and reads back all 64 registers with an arithmetic pattern and alternates the delimiter value. A wrong frame position or bit order would show up as wrong read bytes, and an off-by-one in the read shifter would drop or repeat the first bit. It runs a second command inside one select assertion, aborts a write, a clear and a set partway through, and feeds in undefined opcodes. A design that failed to lock after one command, or that acted on a partial frame, would show extra strobes or a changed latch in later writes. Writes to addresses 64 and above are checked against the register at the aliased low address, which catches a design that drops the upper address bits.

// File: rtl/spi_rf_pkg.sv
// Package: shared constants and types for the serial register access port.
// Assumes an 8-bit opcode field; opcode values are fixed by the protocol.
package spi_rf_pkg;
    localparam int FIELD_BITS = 8;

    localparam logic [FIELD_BITS-1:0] OPC_SET_WEN = 8'h06;
    localparam logic [FIELD_BITS-1:0] OPC_CLR_WEN = 8'h04;
    localparam logic [FIELD_BITS-1:0] OPC_READ    = 8'h03;
    localparam logic [FIELD_BITS-1:0] OPC_WRITE   = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DELIM,
        ST_WDATA,
        ST_RDATA,
        ST_LOCK
    } frame_st_t;

    typedef enum logic [1:0] {
        CMD_SET_WEN,
        CMD_CLR_WEN,
        CMD_READ,
        CMD_WRITE
    } cmd_t;
endpackage

// File: rtl/spi_rf_sync.sv
// Module: multi-bit level synchronizer, one independent flop chain per bit.
// Assumes each bit is a slow level; no bus coherency is implied.
module spi_rf_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first capture of the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= rst_val;
                    else        chain[g] <= d_in;
                end
            end else begin : g_next
                // Purpose: further settling stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= rst_val;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/spi_rf_frame.sv
// Module: command frame decoder. It counts serial bits, decodes the opcode,
// holds the address, keeps the write-enable latch, issues the write strobe
// and asks the transmitter to load read data.
// Assumes rise_ev marks one system cycle per rising serial clock edge, with
// si_s aligned to it, and cs_act already synchronized.
module spi_rf_frame
    import spi_rf_pkg::*;
#(
    parameter int FIELD_W = FIELD_BITS,
    parameter int REG_AW  = 6,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              rise_ev,
    input  logic              si_s,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              we_latch,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_data,
    output logic              rd_active
);
    localparam int CW = $clog2(FIELD_W);
    localparam logic [CW-1:0] LAST_BIT = CW'(FIELD_W - 1);

    frame_st_t          state;
    cmd_t               cmd;
    logic [CW-1:0]      bit_cnt;
    logic [FIELD_W-2:0] rx_sh;
    logic               addr_ok;
    logic [FIELD_W-1:0] full_field;
    logic               field_done;
    logic               field_in_range;
    logic               opc_known;
    cmd_t               opc_cmd;

    assign full_field = {rx_sh, si_s};
    assign field_done = (bit_cnt == LAST_BIT);

    // Upper address bits must be zero for the address to name a register.
    generate
        if (REG_AW < FIELD_W) begin : g_range
            assign field_in_range = ~|full_field[FIELD_W-1:REG_AW];
        end else begin : g_full
            assign field_in_range = 1'b1;
        end
    endgenerate

    // Purpose: map an opcode field to a command, flag unknown codes.
    always_comb begin
        opc_known = 1'b1;
        opc_cmd   = CMD_READ;
        if (full_field == FIELD_W'(OPC_SET_WEN))      opc_cmd = CMD_SET_WEN;
        else if (full_field == FIELD_W'(OPC_CLR_WEN)) opc_cmd = CMD_CLR_WEN;
        else if (full_field == FIELD_W'(OPC_READ))    opc_cmd = CMD_READ;
        else if (full_field == FIELD_W'(OPC_WRITE))   opc_cmd = CMD_WRITE;
        else                                          opc_known = 1'b0;
    end

    // Purpose: frame sequencing, latch, strobe and read-load control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cmd       <= CMD_READ;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            addr_ok   <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            we_latch  <= 1'b0;
            tx_load   <= 1'b0;
            tx_data   <= '0;
        end else begin
            reg_we  <= 1'b0;
            tx_load <= 1'b0;
            if (!cs_act) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
            end else if (rise_ev) begin
                rx_sh   <= full_field[FIELD_W-2:0];
                bit_cnt <= field_done ? '0 : bit_cnt + 1'b1;
                case (state)
                    ST_IDLE, ST_OPC: begin
                        state <= ST_OPC;
                        if (field_done) begin
                            cmd   <= opc_cmd;
                            state <= opc_known ? ST_ADDR : ST_LOCK;
                        end
                    end
                    ST_ADDR: begin
                        if (field_done) begin
                            reg_addr <= full_field[REG_AW-1:0];
                            addr_ok  <= field_in_range;
                            state    <= ST_DELIM;
                        end
                    end
                    ST_DELIM: begin
                        bit_cnt <= '0;
                        case (cmd)
                            CMD_SET_WEN: begin
                                we_latch <= 1'b1;
                                state    <= ST_LOCK;
                            end
                            CMD_CLR_WEN: begin
                                we_latch <= 1'b0;
                                state    <= ST_LOCK;
                            end
                            CMD_READ: begin
                                tx_load <= 1'b1;
                                tx_data <= addr_ok ? reg_rdata : '0;
                                state   <= ST_RDATA;
                            end
                            default: state <= ST_WDATA;
                        endcase
                    end
                    ST_WDATA: begin
                        if (field_done) begin
                            reg_wdata <= full_field[DATA_W-1:0];
                            reg_we    <= we_latch & addr_ok;
                            state     <= ST_LOCK;
                        end
                    end
                    ST_RDATA: begin
                        if (field_done) state <= ST_LOCK;
                    end
                    default: state <= ST_LOCK;
                endcase
            end else if (state == ST_IDLE) begin
                state <= ST_OPC;
            end
        end
    end

    assign rd_active = (state == ST_RDATA);
endmodule

// File: rtl/spi_rf_tx.sv
// Module: read data shifter. It loads a byte, presents the MSB at once and
// advances one bit on each falling serial edge that follows a rising edge.
// Assumes load arrives before the first data-phase rising edge.
module spi_rf_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              active,
    input  logic              rise_ev,
    input  logic              fall_ev,
    output logic              so
);
    logic [DATA_W-1:0] sh;
    logic              pend;

    // Purpose: hold and advance the outgoing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            pend <= 1'b0;
        end else if (load) begin
            sh   <= load_data;
            pend <= 1'b0;
        end else begin
            if (active && rise_ev) pend <= 1'b1;
            if (fall_ev && pend) begin
                sh   <= {sh[DATA_W-2:0], 1'b0};
                pend <= 1'b0;
            end
        end
    end

    assign so = active & sh[DATA_W-1];
endmodule

// File: rtl/spi_rf_slave.sv
// Module: top of the serial register access port. It synchronizes the
// serial pins, finds clock edges and joins the frame decoder to the read
// shifter. Assumes the serial clock half period is at least four system
// clocks, and mode 0 (idle low, sample on rise).
module spi_rf_slave
    import spi_rf_pkg::*;
#(
    parameter int REG_AW      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic [2:0]        pins_s;
    logic              sclk_d;
    logic              cs_act;
    logic              rise_ev;
    logic              fall_ev;
    logic              we_latch;
    logic              tx_load;
    logic [DATA_W-1:0] tx_data;
    logic              rd_active;

    spi_rf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (3'b100),
        .d_in    ({cs_n, sclk, si}),
        .q_out   (pins_s)
    );

    // Purpose: remember last synchronized serial clock for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= pins_s[1];
    end

    assign cs_act  = ~pins_s[2];
    assign rise_ev = pins_s[1] & ~sclk_d;
    assign fall_ev = ~pins_s[1] & sclk_d;

    spi_rf_frame #(.FIELD_W(FIELD_BITS), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .rise_ev   (rise_ev),
        .si_s      (pins_s[0]),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .we_latch  (we_latch),
        .tx_load   (tx_load),
        .tx_data   (tx_data),
        .rd_active (rd_active)
    );

    spi_rf_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_data (tx_data),
        .active    (rd_active),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev),
        .so        (so)
    );
endmodule

// File: rtl/spi_rf_slave_chk.sv
// Module: assertion checker for spi_rf_slave, attached by bind below.
module spi_rf_slave_chk #(
    parameter int REG_AW = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic              so,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic              we_latch
);
    logic [1:0] wr_in_sel;

    // Purpose: count write strobes within one select assertion.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) wr_in_sel <= '0;
        else if (reg_we && wr_in_sel != 2'd3) wr_in_sel <= wr_in_sel + 2'd1;
    end

    // R7
    so_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && !$past(cs_act)) |-> !so);

    // R3
    we_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R3
    we_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $stable(reg_addr));

    // R8
    one_write_per_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (wr_in_sel == 2'd0));

    // R10
    latch_quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && !$past(cs_act)) |-> $stable(we_latch));
endmodule

bind spi_rf_slave spi_rf_slave_chk #(.REG_AW(REG_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .so       (so),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .we_latch (we_latch)
);

// File: tb/tb_spi_rf_slave.sv
// Bench: sweeps all registers, then runs the lock, abort, opcode and range corners.
module tb_spi_rf_slave;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       si = 1'b0;
    logic       so;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;

    logic [7:0] mem [64];
    logic [7:0] expv [64];
    int         we_cnt = 0;
    int         last_a = 0;
    int         last_d = 0;
    int         checks = 0;
    int         failures = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    spi_rf_slave dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si), .so(so),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (rst_n && reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
            last_a <= int'(reg_addr);
            last_d <= int'(reg_wdata);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 7) & 255);
    endfunction

    task automatic clk_bit(input logic b, output logic o);
        si = b;
        repeat (HALF) @(negedge clk);
        o = so;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    // One select assertion: nb bits of vec, then ne bits of ext.
    task automatic run_frame(input logic [24:0] vec, input int nb, input logic [24:0] ext,
                             input int ne, input logic is_rd, output logic [7:0] rd,
                             output logic so_bad);
        logic o;
        rd = '0;
        so_bad = 1'b0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            clk_bit(vec[24-i], o);
            if (is_rd && i >= 17) rd = {rd[6:0], o};
            else if (o) so_bad = 1'b1;
        end
        for (int i = 0; i < ne; i++) begin
            clk_bit(ext[24-i], o);
            if (o) so_bad = 1'b1;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        if (so) so_bad = 1'b1;
        repeat (3 * HALF) @(negedge clk);
        if (so) so_bad = 1'b1;
    endtask

    task automatic wr(input int a, input logic [7:0] d, input logic dl, output logic bad);
        logic [7:0] r;
        run_frame({8'h02, 8'(a), dl, d}, 25, '0, 0, 1'b0, r, bad);
    endtask

    task automatic rdreg(input int a, input logic dl, output logic [7:0] r, output logic bad);
        run_frame({8'h03, 8'(a), dl, 8'h00}, 25, '0, 0, 1'b1, r, bad);
    endtask

    task automatic opcmd(input logic [7:0] op);
        logic [7:0] r;
        logic b;
        run_frame({op, 8'h00, 1'b1, 8'h00}, 17, '0, 0, 1'b0, r, b);
        chk("R7 so low in command frame", int'(b), 0);
    endtask

    task automatic readall(input string tag);
        logic [7:0] r;
        logic b;
        for (int a = 0; a < 64; a++) begin
            rdreg(a, a[0], r, b);
            chk(tag, int'(r), int'(expv[a]));
        end
    endtask

    initial begin
        logic [7:0] r;
        logic       b;
        int         n0;
        for (int a = 0; a < 64; a++) begin
            mem[a] = 8'h00;
            expv[a] = 8'h00;
        end
        repeat (5) @(negedge clk);
        // R1: reset state at the ports
        chk("R1 so at reset", int'(so), 0);
        chk("R1 reg_we at reset", int'(reg_we), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 / R4: write before any enable is dropped
        wr(3, 8'h5A, 1'b1, b);
        chk("R4 no strobe with latch clear", we_cnt, 0);
        rdreg(3, 1'b0, r, b);
        chk("R1 latch clear after reset", int'(r), 0);

        // R5 set, then R2/R3 sweep over all registers
        opcmd(8'h06);
        for (int a = 0; a < 64; a++) begin
            n0 = we_cnt;
            wr(a, pat(a), a[1], b);
            expv[a] = pat(a);
            chk("R3 one strobe per write", we_cnt - n0, 1);
            chk("R3 strobe address", last_a, a);
            chk("R3 strobe data", last_d, int'(pat(a)));
            chk("R7 so low during write", int'(b), 0);
        end
        // R6 / R2: read every register back
        readall("R6 read back sweep");
        rdreg(9, 1'b1, r, b);
        chk("R7 so low after read", int'(b), 0);

        // R11: out of range addresses
        n0 = we_cnt;
        for (int k = 0; k < 12; k++) begin
            wr(64 + k * 17, 8'hEE, 1'b0, b);
        end
        chk("R11 no strobe for high address", we_cnt - n0, 0);
        rdreg(70, 1'b0, r, b);
        chk("R11 high address reads zero", int'(r), 0);
        rdreg(255, 1'b1, r, b);
        chk("R11 address 255 reads zero", int'(r), 0);
        readall("R11 no aliasing into low registers");

        // R8: second command in the same select is ignored
        n0 = we_cnt;
        run_frame({8'h02, 8'd7, 1'b0, 8'hC3}, 25, {8'h02, 8'd8, 1'b0, 8'h3C}, 25, 1'b0, r, b);
        expv[7] = 8'hC3;
        chk("R8 single strobe per select", we_cnt - n0, 1);
        rdreg(8, 1'b0, r, b);
        chk("R8 trailing write ignored", int'(r), int'(expv[8]));
        rdreg(7, 1'b0, r, b);
        chk("R8 first write done", int'(r), 8'hC3);
        // R8 / R5: clear then trailing set in one select leaves latch clear
        run_frame({8'h04, 8'd0, 1'b1, 8'h00}, 17, {8'h06, 8'd0, 1'b1, 8'h00}, 17, 1'b0, r, b);
        n0 = we_cnt;
        wr(12, 8'h99, 1'b0, b);
        chk("R5 clear blocks write", we_cnt - n0, 0);
        chk("R8 trailing set ignored", int'(mem[12]), int'(expv[12]));

        // R10: aborted set keeps latch clear
        run_frame({8'h06, 8'd0, 1'b1, 8'h00}, 16, '0, 0, 1'b0, r, b);
        n0 = we_cnt;
        wr(13, 8'h77, 1'b1, b);
        chk("R10 aborted set has no effect", we_cnt - n0, 0);
        opcmd(8'h06);
        // R10: aborted clear keeps latch set, aborted write changes nothing
        run_frame({8'h04, 8'd0, 1'b1, 8'h00}, 12, '0, 0, 1'b0, r, b);
        n0 = we_cnt;
        run_frame({8'h02, 8'd5, 1'b0, 8'hA5}, 21, '0, 0, 1'b0, r, b);
        chk("R10 aborted write no strobe", we_cnt - n0, 0);
        wr(13, 8'h77, 1'b1, b);
        expv[13] = 8'h77;
        chk("R10 aborted clear keeps latch", we_cnt - n0, 1);
        rdreg(5, 1'b1, r, b);
        chk("R10 register untouched by abort", int'(r), int'(expv[5]));

        // R9: unknown opcodes with write-like bodies, latch set
        n0 = we_cnt;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] op;
            case (k)
                0: op = 8'h00; 1: op = 8'h01; 2: op = 8'h05;
                3: op = 8'h07; 4: op = 8'h83; default: op = 8'hFF;
            endcase
            run_frame({op, 8'd20, 1'b0, 8'hFF}, 25, '0, 0, 1'b0, r, b);
            chk("R9 so idle for unknown opcode", int'(b), 0);
        end
        chk("R9 unknown opcodes no strobe", we_cnt - n0, 0);
        // R9: latch still set after unknown opcodes
        wr(21, 8'h4B, 1'b0, b);
        expv[21] = 8'h4B;
        chk("R9 latch unchanged", we_cnt - n0, 1);

        // R5 final clear and R4 ignored write
        opcmd(8'h04);
        n0 = we_cnt;
        wr(30, 8'h11, 1'b1, b);
        chk("R4 write ignored after clear", we_cnt - n0, 0);
        readall("R6 final image");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule